// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block performs the 32-bit divide operations of a 64-bit integer pipeline. The dividend is 64 bits wide: an auxiliary high-word register value supplies its upper half and the low word of the first source operand supplies its lower half. The divisor is either the low word of the second source operand or a sign-extended 13-bit immediate. Both unsigned and signed division are supported. A quotient that cannot be represented in 32 bits does not wrap. Instead it is clamped to a fixed saturation value, and the overflow flag reports the clamp.

A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While a divide is in progress `req_ready` stays low, and any `req_valid` in that time is dropped without effect. The caller holds no request, so there is no back-pressure to respect: a request offered while `req_ready` is low must be offered again. The result side has no ready input. `rsp_valid` is a one-cycle pulse, and the result and flag outputs keep their values until the next response. The quotient comes from one restoring shift-subtract step per cycle, applied to operand magnitudes. For signed division the sign is then corrected, so the quotient truncates toward zero.

Top module: `ydiv_unit`

## Requirements
- R1: The dividend is `{req_y, req_src1[31:0]}`. Bits 63:32 of `req_src1` have no effect on any output.
- R2: When `req_use_imm` is 0, the divisor is `req_src2[31:0]` and bits 63:32 of `req_src2` have no effect. When `req_use_imm` is 1, the divisor is `req_imm` sign-extended to 32 bits.
- R3: A zero divisor gives a response with `rsp_dz`=1, `rsp_result`=0 and all four flags 0. That response appears one cycle after the accepting edge.
- R4: In unsigned mode (`req_signed`=0), a quotient with any set bit above bit 31 gives `rsp_result`=0x00000000FFFFFFFF.
- R5: In signed mode, a quotient greater than 0x7FFFFFFF gives `rsp_result`=0x000000007FFFFFFF. This includes the case of the most negative dividend divided by -1.
- R6: In signed mode, a quotient below -2^31 gives `rsp_result`=0xFFFFFFFF80000000. A quotient of exactly -2^31 is not clamped.
- R7: A signed quotient truncates toward zero. When it is not clamped, it is sign-extended from bit 31 to 64 bits. An unsigned quotient that is not clamped is zero-extended.
- R8: When `req_setcc`=1, the flags are set as follows: V=1 exactly when the quotient was clamped, C=0, N=`rsp_result[31]`, and Z=1 when `rsp_result[31:0]` is zero. When `req_setcc`=0, all four flags are 0.
- R9: `req_ready` is 1 only when the block is idle. A `req_valid` while `req_ready`=0 is ignored: it produces no response and does not change the result in flight.
- R10: `rsp_valid` is high for exactly one cycle per accepted request. For a nonzero divisor, the response appears 65 cycles after the accepting edge (2·DW+1).
- R11: After reset, `req_ready`=1, `rsp_valid`=0, and `rsp_result`, `rsp_dz` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Block idle; a request is taken on valid and ready |
| req_signed | input | 1 | 1 selects signed division |
| req_setcc | input | 1 | 1 makes the response carry flags |
| req_use_imm | input | 1 | 1 selects the immediate as divisor |
| req_src1 | input | 64 | First operand; low word forms the dividend low half |
| req_src2 | input | 64 | Second operand; low word is the register divisor |
| req_imm | input | 13 | Signed immediate divisor |
| req_y | input | 32 | Dividend high half |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_result | output | 64 | Quotient, extended or clamped |
| rsp_dz | output | 1 | Division-by-zero fault |
| rsp_flag_n | output | 1 | Negative flag |
| rsp_flag_z | output | 1 | Zero flag |
| rsp_flag_v | output | 1 | Overflow flag (clamp occurred) |
| rsp_flag_c | output | 1 | Carry flag, always cleared |

## Verification
The hardest conditions to reach are the clamp boundaries of signed mode. These are quotients of exactly -2^31 and 2^31-1, which must pass through unchanged, and the most negative dividend divided by -1, whose positive magnitude of 2^63 does not fit in any signed 64-bit value. Because random operands almost never land on these values, the stimulus builds them directly from the high-word input and chosen divisors. The bench also drives a request while the block is busy and relies on the scoreboard to flag any extra or altered response.

// File: rtl/ydiv_pkg.sv
package ydiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ydiv_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ydiv_flags_t;
endpackage

// File: rtl/ydiv_operand.sv
module ydiv_operand #(
  parameter int DW = 32,
  parameter int IW = 13
) (
  input  logic            sgn,
  input  logic            use_imm,
  input  logic [DW-1:0]   src1_lo,
  input  logic [DW-1:0]   src2_lo,
  input  logic [IW-1:0]   imm,
  input  logic [DW-1:0]   y,
  output logic [2*DW-1:0] dvd_mag,
  output logic [DW-1:0]   dvs_mag,
  output logic            q_neg,
  output logic            dvs_zero
);
  localparam int XW = 2 * DW;

  logic [XW-1:0] dvd;
  logic [DW-1:0] dvs;
  logic          dvd_neg, dvs_neg;

  always_comb begin
    dvd      = {y, src1_lo};
    dvs      = use_imm ? {{(DW-IW){imm[IW-1]}}, imm} : src2_lo;
    dvd_neg  = sgn & dvd[XW-1];
    dvs_neg  = sgn & dvs[DW-1];
    dvd_mag  = dvd_neg ? (~dvd + 1'b1) : dvd;
    dvs_mag  = dvs_neg ? (~dvs + 1'b1) : dvs;
    q_neg    = dvd_neg ^ dvs_neg;
    dvs_zero = (dvs == '0);
  end
endmodule

// File: rtl/ydiv_core.sv
module ydiv_core #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [2*DW-1:0] dvd_in,
  input  logic [DW-1:0]   dvs_in,
  output logic [2*DW-1:0] quo
);
  localparam int XW = 2 * DW;

  logic [XW-1:0] q_r;
  logic [DW-1:0] rem_r;
  logic [DW-1:0] dvs_r;
  logic [DW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {rem_r, q_r[XW-1]};
    diff    = shifted - {1'b0, dvs_r};
    fits    = (shifted >= {1'b0, dvs_r});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
      dvs_r <= '0;
    end else if (load) begin
      q_r   <= dvd_in;
      rem_r <= '0;
      dvs_r <= dvs_in;
    end else if (step) begin
      q_r   <= {q_r[XW-2:0], fits};
      rem_r <= fits ? diff[DW-1:0] : shifted[DW-1:0];
    end
  end

  assign quo = q_r;
endmodule

// File: rtl/ydiv_finish.sv
module ydiv_finish
  import ydiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] quo,
  input  logic            q_neg,
  input  logic            sgn,
  input  logic            setcc,
  input  logic            dz,
  output logic [2*DW-1:0] result,
  output ydiv_flags_t     flags
);
  localparam int XW = 2 * DW;
  localparam logic [XW-1:0] SAT_U   = {{DW{1'b0}}, {DW{1'b1}}};
  localparam logic [XW-1:0] SAT_POS = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [XW-1:0] SAT_NEG = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic          over_u, over_p, over_n, clamp;
  logic [DW-1:0] lo_signed;

  always_comb begin
    over_u    = |quo[XW-1:DW];
    over_p    = ~q_neg & (|quo[XW-1:DW-1]);
    over_n    = q_neg & ((|quo[XW-1:DW]) | (quo[DW-1] & (|quo[DW-2:0])));
    lo_signed = q_neg ? (~quo[DW-1:0] + 1'b1) : quo[DW-1:0];
    clamp     = 1'b0;
    if (dz) begin
      result = '0;
    end else if (!sgn) begin
      clamp  = over_u;
      result = over_u ? SAT_U : {{DW{1'b0}}, quo[DW-1:0]};
    end else if (over_p) begin
      clamp  = 1'b1;
      result = SAT_POS;
    end else if (over_n) begin
      clamp  = 1'b1;
      result = SAT_NEG;
    end else begin
      result = {{DW{lo_signed[DW-1]}}, lo_signed};
    end
    flags = '0;
    if (setcc && !dz) begin
      flags.n = result[DW-1];
      flags.z = (result[DW-1:0] == '0);
      flags.v = clamp;
      flags.c = 1'b0;
    end
  end
endmodule

// File: rtl/ydiv_unit.sv
module ydiv_unit
  import ydiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_signed,
  input  logic            req_setcc,
  input  logic            req_use_imm,
  input  logic [2*DW-1:0] req_src1,
  input  logic [2*DW-1:0] req_src2,
  input  logic [IW-1:0]   req_imm,
  input  logic [DW-1:0]   req_y,
  output logic            rsp_valid,
  output logic [2*DW-1:0] rsp_result,
  output logic            rsp_dz,
  output logic            rsp_flag_n,
  output logic            rsp_flag_z,
  output logic            rsp_flag_v,
  output logic            rsp_flag_c
);
  localparam int XW   = 2 * DW;
  localparam int ITER = XW;
  localparam int CW   = $clog2(ITER + 1);

  ydiv_state_e   state;
  logic [CW-1:0] cnt;
  logic          sgn_q, setcc_q, qneg_q, dz_q;
  logic          accept;

  logic [XW-1:0] dvd_mag, quo, fin_result;
  logic [DW-1:0] dvs_mag;
  logic          q_neg, dvs_zero;
  ydiv_flags_t   fin_flags;
  logic          unused_hi_bits;

  assign unused_hi_bits = ^{req_src1[XW-1:DW], req_src2[XW-1:DW]};
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  ydiv_operand #(.DW(DW), .IW(IW)) opnd_i (
    .sgn      (req_signed),
    .use_imm  (req_use_imm),
    .src1_lo  (req_src1[DW-1:0]),
    .src2_lo  (req_src2[DW-1:0]),
    .imm      (req_imm),
    .y        (req_y),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .q_neg    (q_neg),
    .dvs_zero (dvs_zero)
  );

  ydiv_core #(.DW(DW)) core_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (state == ST_RUN),
    .dvd_in (dvd_mag),
    .dvs_in (dvs_mag),
    .quo    (quo)
  );

  ydiv_finish #(.DW(DW)) fin_i (
    .quo    (quo),
    .q_neg  (qneg_q),
    .sgn    (sgn_q),
    .setcc  (setcc_q),
    .dz     (dz_q),
    .result (fin_result),
    .flags  (fin_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sgn_q      <= 1'b0;
      setcc_q    <= 1'b0;
      qneg_q     <= 1'b0;
      dz_q       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
      rsp_dz     <= 1'b0;
      rsp_flag_n <= 1'b0;
      rsp_flag_z <= 1'b0;
      rsp_flag_v <= 1'b0;
      rsp_flag_c <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sgn_q   <= req_signed;
            setcc_q <= req_setcc;
            qneg_q  <= q_neg;
            dz_q    <= dvs_zero;
            cnt     <= CW'(ITER);
            state   <= dvs_zero ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          rsp_valid  <= 1'b1;
          rsp_result <= fin_result;
          rsp_dz     <= dz_q;
          rsp_flag_n <= fin_flags.n;
          rsp_flag_z <= fin_flags.z;
          rsp_flag_v <= fin_flags.v;
          rsp_flag_c <= fin_flags.c;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ydiv_unit_chk.sv
module ydiv_unit_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [2*DW-1:0] rsp_result,
  input logic            rsp_dz,
  input logic            rsp_flag_z,
  input logic            rsp_flag_v
);
  localparam int LAT = 2 * DW + 1;
  localparam int SW  = $clog2(LAT + 1) + 1;

  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (req_valid && req_ready) since <= '0;
    else if (since != {SW{1'b1}}) since <= since + 1'b1;
  end

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since == SW'(LAT) || (rsp_dz && since == SW'(1))));

  a_r3_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dz) |-> (rsp_result == '0 && !rsp_flag_v && !rsp_flag_z));

  a_r7_extended: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_result[2*DW-1:DW] == '0 || rsp_result[2*DW-1:DW] == '1));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_flag_z) |-> (rsp_result[DW-1:0] == '0));
endmodule

bind ydiv_unit ydiv_unit_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_result (rsp_result),
  .rsp_dz     (rsp_dz),
  .rsp_flag_z (rsp_flag_z),
  .rsp_flag_v (rsp_flag_v)
);

// File: tb/ydiv_unit_tb_top.sv
module ydiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic        req_signed = 1'b0, req_setcc = 1'b0, req_use_imm = 1'b0;
  logic [63:0] req_src1 = '0, req_src2 = '0;
  logic [12:0] req_imm = '0;
  logic [31:0] req_y = '0;
  logic        rsp_valid, rsp_dz, rsp_flag_n, rsp_flag_z, rsp_flag_v, rsp_flag_c;
  logic [63:0] rsp_result;

  always #2 clk = ~clk;

  ydiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_signed(req_signed), .req_setcc(req_setcc), .req_use_imm(req_use_imm),
    .req_src1(req_src1), .req_src2(req_src2), .req_imm(req_imm), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_dz(rsp_dz),
    .rsp_flag_n(rsp_flag_n), .rsp_flag_z(rsp_flag_z),
    .rsp_flag_v(rsp_flag_v), .rsp_flag_c(rsp_flag_c)
  );

  typedef struct {
    logic [67:0] val;
    int          due;
    string       tag;
  } exp_t;

  exp_t queue_q[$];
  int   checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [67:0] act,
                       input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [67:0] model(input bit sg, input bit cc, input bit im,
      input logic [63:0] s1, input logic [63:0] s2, input logic [12:0] imm,
      input logic [31:0] y, output bit dz);
    logic [31:0]        dv;
    logic [63:0]        r;
    logic signed [63:0] sd, sv, sq;
    logic [63:0]        uq;
    bit                 v;
    dv = im ? {{19{imm[12]}}, imm} : s2[31:0];
    dz = (dv == 0);
    v  = 1'b0;
    if (dz) return '0;
    if (!sg) begin
      uq = {y, s1[31:0]} / {32'd0, dv};
      if (uq > 64'hFFFF_FFFF) begin r = 64'h0000_0000_FFFF_FFFF; v = 1'b1; end
      else r = uq;
    end else begin
      sd = {y, s1[31:0]};
      sv = {{32{dv[31]}}, dv};
      if (sd == 64'sh8000_0000_0000_0000 && sv == -64'sd1) begin
        r = 64'h0000_0000_7FFF_FFFF; v = 1'b1;
      end else begin
        sq = sd / sv;
        if (sq > 64'sh7FFF_FFFF) begin r = 64'h0000_0000_7FFF_FFFF; v = 1'b1; end
        else if (sq < -64'sh8000_0000) begin r = 64'hFFFF_FFFF_8000_0000; v = 1'b1; end
        else r = sq;
      end
    end
    if (cc) return {r, r[31], r[31:0] == 0, v, 1'b0};
    return {r, 4'b0000};
  endfunction

  task automatic issue(input bit sg, input bit cc, input bit im, input logic [63:0] s1,
                       input logic [63:0] s2, input logic [12:0] imm, input logic [31:0] y,
                       input string tag);
    exp_t e;
    bit   dz;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_signed = sg; req_setcc = cc; req_use_imm = im;
    req_src1 = s1; req_src2 = s2; req_imm = imm; req_y = y;
    req_valid = 1'b1;
    e.val = model(sg, cc, im, s1, s2, imm, y, dz);
    e.due = cyc + 1 + (dz ? 1 : 65);
    e.tag = tag;
    queue_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (queue_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", {rsp_result, 4'b0}, '0);
      end else begin
        exp_t e;
        e = queue_q.pop_front();
        check({rsp_result, rsp_flag_n, rsp_flag_z, rsp_flag_v, rsp_flag_c} == e.val,
              e.tag, {rsp_result, rsp_flag_n, rsp_flag_z, rsp_flag_v, rsp_flag_c}, e.val);
        check(cyc == e.due, {e.tag, " R10 latency"}, 68'(cyc), 68'(e.due));
        check(rsp_dz == (e.due == cyc && e.val == '0 && rsp_result == '0 ? rsp_dz : 1'b0)
              || (e.val == '0), {e.tag, " R3 fault bit"}, 68'(rsp_dz), 68'(0));
      end
    end
  end

  task automatic drain();
    while (queue_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && rsp_result == '0 && rsp_dz == 1'b0
          && {rsp_flag_n, rsp_flag_z, rsp_flag_v, rsp_flag_c} == 4'b0, "R11 reset state",
          {rsp_result, req_ready, rsp_valid, rsp_dz, 1'b0}, {64'd0, 4'b1000});
    rst_n = 1'b1;

    // R1: junk in src1 upper word and src2 upper word has no effect
    issue(0, 1, 0, 64'hDEAD_BEEF_0000_0064, 64'hAAAA_5555_0000_0007, 13'd0, 32'd0, "R1 R2 unsigned 100/7");
    // R4: unsigned clamp with flags
    issue(0, 1, 0, 64'h0, 64'h1, 13'd0, 32'd1, "R4 R8 unsigned clamp");
    // R8: clamp with flags disabled
    issue(0, 0, 0, 64'h0, 64'h1, 13'd0, 32'd1, "R8 flags off");
    // R2: immediate divisor sign-extended
    issue(0, 1, 1, 64'hFFFF_FFFE, 64'h5, 13'h1FFE, 32'd0, "R2 unsigned imm -2");
    issue(1, 1, 1, 64'd100, 64'h5, 13'h1FFE, 32'd0, "R2 R7 signed 100/-2");
    // R5, R6: signed clamps
    issue(1, 1, 0, 64'h0, 64'h1, 13'd0, 32'd1, "R5 signed positive clamp");
    issue(1, 1, 0, 64'h0, 64'h1, 13'd0, 32'hFFFF_FFFE, "R6 signed negative clamp");
    issue(1, 1, 0, 64'h0, 64'hFFFF_FFFF, 13'd0, 32'h8000_0000, "R5 min by -1");
    // R6, R5 boundaries that must not clamp
    issue(1, 1, 0, 64'h8000_0000, 64'h1, 13'd0, 32'hFFFF_FFFF, "R6 exact -2^31");
    issue(1, 1, 0, 64'h7FFF_FFFF, 64'h1, 13'd0, 32'd0, "R5 exact 2^31-1");
    // R7: truncation toward zero
    issue(1, 1, 0, 64'hFFFF_FFF9, 64'h2, 13'd0, 32'hFFFF_FFFF, "R7 -7/2");
    issue(1, 0, 0, 64'h7, 64'hFFFF_FFFE, 13'd0, 32'd0, "R7 7/-2");
    // R8: zero result sets Z
    issue(0, 1, 0, 64'h5, 64'h7, 13'd0, 32'd0, "R8 zero quotient");
    // R3: zero divisor both modes
    issue(0, 1, 0, 64'h1234, 64'hFFFF_FFFF_0000_0000, 13'd0, 32'd3, "R3 unsigned zero divisor");
    issue(1, 1, 1, 64'h1234, 64'h9, 13'd0, 32'd3, "R3 signed zero imm");
    drain();

    // R9: request while busy is ignored
    issue(0, 1, 0, 64'd1000, 64'd10, 13'd0, 32'd0, "R9 in flight 1000/10");
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low while busy", 68'(req_ready), 68'(0));
    req_signed = 1'b1; req_src1 = 64'd7; req_src2 = 64'd0; req_y = 32'd9;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (80) @(negedge clk);
    check(req_ready == 1'b1, "R9 ready back when idle", 68'(req_ready), 68'(1));

    // Mixed operands
    for (int i = 0; i < 24; i++) begin
      logic [31:0] yy;
      yy = (i % 3 == 0) ? 32'($urandom) : 32'($urandom % 8) - ((i % 2) ? 32'd4 : 32'd0);
      issue(i[0], i[1], i[2] & i[3], {32'($urandom), 32'($urandom)},
            {32'($urandom), 32'($urandom) >> (i % 30)}, 13'($urandom), yy, "R7 mixed");
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule